// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block merges the summary lines of four GPIO banks with six further peripheral interrupt sources into one host interrupt line. Every cycle the controller copies all ten request levels into a read-only pending word. Bits 0 to 3 hold the GPIO bank summaries and bits 4 to 9 hold the peripheral sources. The host interrupt is raised when the controller is running, the global enable is set, and at least one pending bit is eligible. A GPIO bit is always eligible, because the GPIO banks do their own masking. A peripheral bit is eligible only when its enable bit is 1.

The host reaches the block through a small register port. A request channel carries an address, a write flag and write data. A response channel returns read data, or zero for a write. Both channels use valid/ready. Only one response is ever in flight. A request is accepted when `req_valid && req_ready`. `req_ready` stays low while a response is waiting and `rsp_ready` is low. A waiting response holds its data stable until it is taken.

The receiving processor detects the interrupt on its rising edge. For that reason, any accepted write pulls `irq_out` low for one cycle. If anything is still eligible afterwards, the line rises again and gives a fresh edge.

Top module: `intr_aggregator`

## Requirements
- R1: Reading address 0 returns the pending word. Bits 3:0 are `gpio_sum[3:0]`, bits 9:4 are `periph_irq[0]` to `periph_irq[5]` in ascending order, and bits 15:10 read 0. Each input is captured one clock after it is applied.
- R2: The pending word is read-only. A write to address 0 changes no state, and a following read of address 0 returns the captured inputs.
- R3: Address 1 is the enable register. Bits 5:0 enable peripheral sources 0 to 5 (1 = enabled, 0 = disabled). Other bits read 0, apart from the global enable. The GPIO pending bits are not affected by bits 5:0.
- R4: Bit 8 of address 1 is the global enable. While it is 0, `irq_out` stays low.
- R5: Bit 0 of address 2 is the run enable. While it is 0, the pending word reads zero and `irq_out` stays low.
- R6: `irq_out` is high when the run enable and the global enable are both set and any GPIO pending bit or enabled peripheral pending bit is set. It follows the inputs with a two-clock latency.
- R7: In the cycle after any accepted write, `irq_out` is low. In the cycle after that it is high again if the R6 condition still holds, which gives a new rising edge.
- R8: After reset, the enable register and the run enable read 0, `irq_out` is low, `rsp_valid` is low and `req_ready` is high.
- R9: A response appears one clock after its request is accepted. It holds `rsp_rdata` stable while `rsp_ready` is low, and `req_ready` is low during that stall. Address 3 reads 0, and writes to it are ignored.
- R10: Peripheral pending bits follow the level of their source. When a source falls, its bit clears and the interrupt it caused is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_sum | input | 4 | Summary request line of each GPIO bank |
| periph_irq | input | 6 | Level requests of the peripheral sources |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address (0 pending, 1 enable, 2 run) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| irq_out | output | 1 | Host interrupt, meant for rising-edge detection |

## Verification
The assertions check on every cycle that:
- a cleared run enable empties the pending word and keeps the interrupt low;
- a cleared global enable keeps the interrupt low;
- every accepted write is followed by a low cycle on the interrupt;
- a stalled response stays stable while new requests are refused;
- the interrupt rises only when something was pending.

The bench scenarios cover what a single-cycle property cannot: the bit layout of the pending word, the independence of GPIO bits from the per-source enables, the line rising again after a write, and sources being withdrawn.

// File: rtl/ia_pkg.sv
package ia_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PEND = 2'd0,
    ADDR_ENAB = 2'd1,
    ADDR_RUN  = 2'd2,
    ADDR_NONE = 2'd3
  } ia_addr_e;
endpackage

// File: rtl/ia_capture.sv
// Samples the request levels into the pending word while running.
module ia_capture #(
  parameter int N_GPIO   = 4,
  parameter int N_PERIPH = 6,
  localparam int PEND_W  = N_GPIO + N_PERIPH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [N_GPIO-1:0]   gpio_sum,
  input  logic [N_PERIPH-1:0] periph_irq,
  output logic [PEND_W-1:0]   pending
);
  logic [PEND_W-1:0] sample;

  // Lower bits take the bank summaries and upper bits take the sources,
  // each group in ascending order.
  for (genvar i = 0; i < PEND_W; i++) begin : g_slot
    if (i < N_GPIO) begin : g_bank
      assign sample[i] = gpio_sum[i];
    end else begin : g_src
      assign sample[i] = periph_irq[i-N_GPIO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pending <= '0;
    else if (run) pending <= sample;
    else          pending <= '0;
  end
endmodule

// File: rtl/ia_regs.sv
// Register port with one response in flight, plus the control registers.
module ia_regs #(
  parameter int DATA_W     = 16,
  parameter int N_PERIPH   = 6,
  parameter int PEND_W     = 10,
  parameter int GLOBAL_BIT = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ia_pkg::ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  input  logic [PEND_W-1:0]     pending,
  output logic [N_PERIPH-1:0]   src_en,
  output logic                  glob_en,
  output logic                  run,
  output logic                  wr_fire
);
  import ia_pkg::*;

  logic              accept;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_fire   = accept && req_write;

  always_comb begin
    rd_mux = '0;
    case (ia_addr_e'(req_addr))
      ADDR_PEND: rd_mux[PEND_W-1:0] = pending;
      ADDR_ENAB: begin
        rd_mux[N_PERIPH-1:0] = src_en;
        rd_mux[GLOBAL_BIT]   = glob_en;
      end
      ADDR_RUN:  rd_mux[0] = run;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en  <= '0;
      glob_en <= 1'b0;
      run     <= 1'b0;
    end else if (wr_fire) begin
      case (ia_addr_e'(req_addr))
        ADDR_ENAB: begin
          src_en  <= req_wdata[N_PERIPH-1:0];
          glob_en <= req_wdata[GLOBAL_BIT];
        end
        ADDR_RUN: run <= req_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ia_irq_out.sv
// Qualifies the pending word and drives the registered host line.
module ia_irq_out #(
  parameter int N_GPIO   = 4,
  parameter int N_PERIPH = 6,
  localparam int PEND_W  = N_GPIO + N_PERIPH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PEND_W-1:0]   pending,
  input  logic [N_PERIPH-1:0] src_en,
  input  logic                glob_en,
  input  logic                run,
  input  logic                wr_fire,
  output logic                irq_out
);
  logic [PEND_W-1:0] eligible;

  // Bank summaries are masked inside the banks; only sources are gated here.
  for (genvar i = 0; i < PEND_W; i++) begin : g_elig
    if (i < N_GPIO) begin : g_bank
      assign eligible[i] = pending[i];
    end else begin : g_src
      assign eligible[i] = pending[i] && src_en[i-N_GPIO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_out <= 1'b0;
    else if (wr_fire) irq_out <= 1'b0;
    else              irq_out <= run && glob_en && (|eligible);
  end
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator #(
  parameter int DATA_W     = 16,
  parameter int N_GPIO     = 4,
  parameter int N_PERIPH   = 6,
  parameter int GLOBAL_BIT = 8,
  localparam int PEND_W    = N_GPIO + N_PERIPH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_GPIO-1:0]     gpio_sum,
  input  logic [N_PERIPH-1:0]   periph_irq,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ia_pkg::ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  irq_out
);
  logic [PEND_W-1:0]   pending;
  logic [N_PERIPH-1:0] src_en;
  logic                glob_en;
  logic                run;
  logic                wr_fire;

  ia_capture #(.N_GPIO(N_GPIO), .N_PERIPH(N_PERIPH)) u_capture (
    .clk(clk), .rst_n(rst_n), .run(run),
    .gpio_sum(gpio_sum), .periph_irq(periph_irq), .pending(pending)
  );

  ia_regs #(.DATA_W(DATA_W), .N_PERIPH(N_PERIPH), .PEND_W(PEND_W),
            .GLOBAL_BIT(GLOBAL_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pending(pending), .src_en(src_en), .glob_en(glob_en), .run(run),
    .wr_fire(wr_fire)
  );

  ia_irq_out #(.N_GPIO(N_GPIO), .N_PERIPH(N_PERIPH)) u_irq (
    .clk(clk), .rst_n(rst_n), .pending(pending), .src_en(src_en),
    .glob_en(glob_en), .run(run), .wr_fire(wr_fire), .irq_out(irq_out)
  );
endmodule

// File: rtl/ia_checker.sv
module ia_checker #(
  parameter int DATA_W = 16,
  parameter int PEND_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              irq_out,
  input logic              run,
  input logic              glob_en,
  input logic [PEND_W-1:0] pending
);
  assert_run_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq_out);

  assert_run_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pending == '0));

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !irq_out);

  assert_write_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !irq_out);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(|pending));
endmodule

bind intr_aggregator ia_checker #(.DATA_W(DATA_W), .PEND_W(PEND_W)) u_ia_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .irq_out(irq_out), .run(run), .glob_en(glob_en),
  .pending(pending)
);

// File: tb/intr_aggregator_bench.sv
module intr_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  gpio_sum = '0;
  logic [5:0]  periph_irq = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  intr_aggregator u_intr_aggregator (
    .clk(clk), .rst_n(rst_n), .gpio_sum(gpio_sum), .periph_irq(periph_irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Driver: one request, expected response pushed to the scoreboard.
  task automatic send(bit wr, logic [1:0] addr, logic [15:0] data,
                      logic [15:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic wr(logic [1:0] addr, logic [15:0] data, string tag);
    send(1'b1, addr, data, 16'h0000, tag);
  endtask

  task automatic rd(logic [1:0] addr, logic [15:0] exp, string tag);
    send(1'b0, addr, 16'h0000, exp, tag);
  endtask

  // Monitor: a valid response with ready high is taken at the next edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected response", rsp_rdata, 16'hxxxx);
        end else begin
          chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R8 irq after reset", {15'd0, irq_out}, 16'd0);
    chk("R8 rsp_valid after reset", {15'd0, rsp_valid}, 16'd0);
    chk("R8 req_ready after reset", {15'd0, req_ready}, 16'd1);
    rd(2'd1, 16'h0000, "R8 enable reg reset");
    rd(2'd2, 16'h0000, "R8 run reg reset");

    // Inputs present while stopped.
    gpio_sum = 4'b0101; periph_irq = 6'b100001;
    cyc(3);
    rd(2'd0, 16'h0000, "R5 pending while stopped");

    wr(2'd2, 16'h0001, "R5 run on write");
    cyc(3);
    rd(2'd0, 16'h0215, "R1 pending layout");
    wr(2'd0, 16'hFFFF, "R2 write to pending");
    cyc(2);
    rd(2'd0, 16'h0215, "R2 pending unchanged");
    rd(2'd2, 16'h0001, "R5 run readback");
    chk("R4 irq with global off", {15'd0, irq_out}, 16'd0);

    // Global on, no source enables: GPIO bits still count.
    wr(2'd1, 16'h0100, "R4 global on");
    chk("R7 low after write", {15'd0, irq_out}, 16'd0);
    cyc(1);
    chk("R6 irq from gpio", {15'd0, irq_out}, 16'd1);
    wr(2'd1, 16'h0100, "R7 rewrite");
    chk("R7 gap on rewrite", {15'd0, irq_out}, 16'd0);
    cyc(1);
    chk("R7 fresh rise", {15'd0, irq_out}, 16'd1);

    // Only peripheral sources, none enabled.
    gpio_sum = 4'b0000;
    cyc(3);
    chk("R3 disabled sources", {15'd0, irq_out}, 16'd0);
    rd(2'd1, 16'h0100, "R3 enable readback");
    wr(2'd1, 16'h0120, "R3 enable source 5");
    chk("R7 low after enable write", {15'd0, irq_out}, 16'd0);
    cyc(1);
    chk("R3 enabled source fires", {15'd0, irq_out}, 16'd1);

    // Source 5 falls, source 0 stays but is disabled.
    periph_irq = 6'b000001;
    cyc(3);
    chk("R10 withdrawn source", {15'd0, irq_out}, 16'd0);
    rd(2'd0, 16'h0010, "R10 pending follows level");

    wr(2'd1, 16'h0001, "R4 global off src0 on");
    cyc(2);
    chk("R4 irq held low", {15'd0, irq_out}, 16'd0);
    wr(2'd1, 16'h0101, "R6 global on src0 on");
    cyc(1);
    chk("R6 irq from source 0", {15'd0, irq_out}, 16'd1);

    wr(2'd2, 16'h0000, "R5 run off");
    cyc(3);
    chk("R5 irq when stopped", {15'd0, irq_out}, 16'd0);
    rd(2'd0, 16'h0000, "R5 pending cleared when stopped");

    rd(2'd3, 16'h0000, "R9 unmapped read");
    wr(2'd3, 16'hFFFF, "R9 unmapped write");
    rd(2'd1, 16'h0101, "R9 enable after unmapped write");
    cyc(2);

    // Back-pressure on the response channel.
    @(negedge clk);
    rsp_ready = 1'b0;
    exp_q.push_back(16'h0101); tag_q.push_back("R9 stalled read data");
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd1;
    @(negedge clk);
    exp_q.push_back(16'h0000); tag_q.push_back("R9 queued read data");
    req_addr = 2'd2;
    #1;
    chk("R9 ready low while stalled", {15'd0, req_ready}, 16'd0);
    cyc(3);
    chk("R9 response held", {15'd0, rsp_valid}, 16'd1);
    chk("R9 data held", rsp_rdata, 16'h0101);
    @(negedge clk);
    rsp_ready = 1'b1;
    #1;
    chk("R9 ready on release", {15'd0, req_ready}, 16'd1);
    @(negedge clk);
    req_valid = 1'b0;
    cyc(4);
    chk("R9 scoreboard drained", 16'(exp_q.size()), 16'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule